// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator with Field-Sequenced Reset

This block produces the running phase of the colour subcarrier for a composite video encoder. A 32-bit accumulator adds a frequency increment word on every pixel clock. The upper bits of the accumulator are meant to address a sine table further down the pipeline. Because the pixel clock and the ideal subcarrier frequency never match exactly, phase error builds up over time. To bound that error, the block can force the accumulator back to a known starting phase at field boundaries.

A field counter advances on each start-of-field strobe. It counts modulo 4 for the 525-line standard and modulo 8 for the 625-line standard, which matches the length of each colour field sequence. Two mode bits choose the reset policy:

- **Automatic:** the phase is reloaded each time the sequence wraps.
- **Request-driven:** a request is held until the next field boundary, where both the phase and the field counter return to field 0.
- **Real-time-control:** the automatic reload is off and requests are still accepted.
- **Free-running:** no reset happens at all.

A one-clock flag marks every forced reload.

Top module: `subcarrier_dds`

## Requirements
- R1: Unless a reload happens, `phase` on each clock becomes its previous value plus `freq_inc`, wrapping modulo 2^32.
- R2: `field_num` is a binary field index. It changes only on a clock with `field_start` high, where it advances by one. It wraps to 0 after 3 when `pal_mode`=0 and after 7 when `pal_mode`=1.
- R3: With `seq_reset_en`=1 and `req_reset_en`=0, the strobe that wraps `field_num` to 0 also loads `phase` with `phase_offset`.
- R4: With `req_reset_en`=1, a clock with `ext_reset_req` high leaves `field_num` unchanged. At the next `field_start` after that clock, `field_num` becomes 0 and `phase` is loaded with `phase_offset`. For example, a request in PAL field 5 makes the following field field 0.
- R5: A request on the same clock as `field_start` does not act on that strobe. It acts on the following strobe.
- R6: With `seq_reset_en`=0 and `req_reset_en`=1, and no request, the phase is never reloaded over any number of fields.
- R7: With both mode bits at 1, the sequence wrap does not reload the phase, while requests still do.
- R8: With both mode bits at 0, requests are ignored and no reload ever happens.
- R9: `reset_pulse` is high for exactly the one clock in which `phase` shows the just-loaded `phase_offset` and `field_num` is 0. It is low at all other times.
- R10: While `rst_n` is low, `phase`, `field_num` and `reset_pulse` are all 0.
- R11: A pending request is discarded if `req_reset_en` is low on any clock before the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | One-clock start-of-field strobe |
| pal_mode | input | 1 | 1 selects the 8-field sequence, 0 selects the 4-field sequence |
| freq_inc | input | 32 | Phase increment added each clock |
| phase_offset | input | 32 | Phase loaded on a reload; normally 0 |
| seq_reset_en | input | 1 | Automatic reload at sequence wrap |
| req_reset_en | input | 1 | Accept external reset requests |
| ext_reset_req | input | 1 | External subcarrier reset request |
| phase | output | 32 | Accumulator phase |
| field_num | output | 3 | Field index within the colour sequence |
| reset_pulse | output | 1 | One-clock flag on each reload |

## Verification
The assertions check four things on every clock:

- the increment law of the accumulator;
- that the field index moves only on a strobe and stays below 4 after an NTSC strobe;
- that every flag pulse coincides with a strobe, field 0 and the offset value;
- that no reload occurs when both mode bits are clear.

Only the bench scenarios can show the deferral of a request to the next boundary and the one-boundary delay for a request that arrives on a strobe. The same holds for the absence of automatic reloads in real-time-control and free-running modes across many fields, and for the discarding of a pending request when requests are disabled.

// File: rtl/subcarrier_dds.sv
module subcarrier_dds #(
  parameter int PHASE_W     = 32,
  parameter int NTSC_FIELDS = 4,
  parameter int PAL_FIELDS  = 8,
  localparam int FIELD_W    = $clog2(PAL_FIELDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               field_start,
  input  logic               pal_mode,
  input  logic [PHASE_W-1:0] freq_inc,
  input  logic [PHASE_W-1:0] phase_offset,
  input  logic               seq_reset_en,
  input  logic               req_reset_en,
  input  logic               ext_reset_req,
  output logic [PHASE_W-1:0] phase,
  output logic [FIELD_W-1:0] field_num,
  output logic               reset_pulse
);

  logic [PHASE_W-1:0] phase_q;
  logic [FIELD_W-1:0] field_q;
  logic               pend_q;
  logic               pulse_q;

  logic [FIELD_W-1:0] last_field;
  logic               at_last;
  logic               seq_fire;
  logic               req_fire;
  logic               force_phase;
  logic               pend_d;

  assign last_field  = pal_mode ? FIELD_W'(PAL_FIELDS - 1) : FIELD_W'(NTSC_FIELDS - 1);
  assign at_last     = field_q >= last_field;
  assign seq_fire    = field_start & seq_reset_en & ~req_reset_en & at_last;
  assign req_fire    = field_start & req_reset_en & pend_q;
  assign force_phase = seq_fire | req_fire;
  assign pend_d      = req_reset_en & ((pend_q & ~field_start) | ext_reset_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      field_q <= '0;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= force_phase ? phase_offset : phase_q + freq_inc;
      if (field_start)
        field_q <= (force_phase | at_last) ? '0 : field_q + 1'b1;
      pend_q  <= pend_d;
      pulse_q <= force_phase;
    end
  end

  assign phase       = phase_q;
  assign field_num   = field_q;
  assign reset_pulse = pulse_q;

endmodule

// File: rtl/subcarrier_dds_chk.sv
module subcarrier_dds_chk #(
  parameter int PHASE_W = 32,
  parameter int FIELD_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               field_start,
  input logic               pal_mode,
  input logic [PHASE_W-1:0] freq_inc,
  input logic [PHASE_W-1:0] phase_offset,
  input logic               seq_reset_en,
  input logic               req_reset_en,
  input logic [PHASE_W-1:0] phase,
  input logic [FIELD_W-1:0] field_num,
  input logic               reset_pulse
);

  logic past_valid;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;

  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && !reset_pulse |-> phase == $past(phase) + $past(freq_inc));

  p_field_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && !$past(field_start) |-> $stable(field_num));

  p_ntsc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && $past(field_start) && !$past(pal_mode) |-> field_num < FIELD_W'(4));

  p_pulse_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && reset_pulse |-> $past(field_start));

  p_pulse_loads_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && reset_pulse |-> (phase == $past(phase_offset)) && (field_num == '0));

  p_no_reload_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && $past(!seq_reset_en && !req_reset_en) |-> !reset_pulse);

  always_comb
    if (!rst_n) p_reset_state_r10: assert (!reset_pulse || $isunknown(reset_pulse));

endmodule

bind subcarrier_dds subcarrier_dds_chk #(.PHASE_W(PHASE_W), .FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_start(field_start), .pal_mode(pal_mode),
  .freq_inc(freq_inc), .phase_offset(phase_offset), .seq_reset_en(seq_reset_en),
  .req_reset_en(req_reset_en), .phase(phase), .field_num(field_num),
  .reset_pulse(reset_pulse)
);

// File: tb/sim_subcarrier_dds.sv
`timescale 1ns/1ps
module sim_subcarrier_dds;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        field_start = 1'b0;
  logic        pal_mode = 1'b0;
  logic [31:0] freq_inc = '0;
  logic [31:0] phase_offset = '0;
  logic        seq_reset_en = 1'b0;
  logic        req_reset_en = 1'b0;
  logic        ext_reset_req = 1'b0;
  logic [31:0] phase;
  logic [2:0]  field_num;
  logic        reset_pulse;

  int checks = 0;
  int errors = 0;
  int npulse = 0;

  always #5 clk = ~clk;

  subcarrier_dds u0 (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .pal_mode(pal_mode),
    .freq_inc(freq_inc), .phase_offset(phase_offset), .seq_reset_en(seq_reset_en),
    .req_reset_en(req_reset_en), .ext_reset_req(ext_reset_req),
    .phase(phase), .field_num(field_num), .reset_pulse(reset_pulse)
  );

  // behavioural reference
  logic [31:0] m_phase = '0;
  int          m_field = 0;
  bit          m_pend = 0;
  bit          m_pulse = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = '0; m_field = 0; m_pend = 0; m_pulse = 0;
    end else begin
      int  n;
      bit  ev;
      bit  np;
      n  = pal_mode ? 8 : 4;
      ev = 0;
      if (field_start) begin
        if (req_reset_en && m_pend) ev = 1;
        if (seq_reset_en && !req_reset_en && m_field >= n - 1) ev = 1;
        m_field = (ev || m_field >= n - 1) ? 0 : m_field + 1;
      end
      np      = req_reset_en && ((m_pend && !field_start) || ext_reset_req);
      m_phase = ev ? phase_offset : m_phase + freq_inc;
      m_pulse = ev;
      m_pend  = np;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 phase vs model", phase, m_phase);
      chk("R2 field vs model", {29'd0, field_num}, m_field);
      chk("R9 pulse vs model", {31'd0, reset_pulse}, {31'd0, m_pulse});
      if (reset_pulse) npulse++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) field_start = 1'b1;
    @(negedge clk) field_start = 1'b0;
  endtask

  task automatic fields(input int n);
    for (int i = 0; i < n; i++) begin
      strobe();
      idle(3);
    end
  endtask

  task automatic request();
    @(negedge clk) ext_reset_req = 1'b1;
    @(negedge clk) ext_reset_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    idle(2);
    chk("R10 phase in reset", phase, 32'd0);
    chk("R10 field in reset", {29'd0, field_num}, 32'd0);
    chk("R10 pulse in reset", {31'd0, reset_pulse}, 32'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    // R3 NTSC automatic
    freq_inc = 32'h9000_0001; seq_reset_en = 1; phase_offset = 32'h0000_1000;
    do_reset();
    idle(4);
    fields(3);
    chk("R2 NTSC field 3", {29'd0, field_num}, 32'd3);
    strobe();
    chk("R3 NTSC wrap field", {29'd0, field_num}, 32'd0);
    chk("R3 NTSC wrap phase", phase, 32'h0000_1000);
    chk("R9 pulse at reload", {31'd0, reset_pulse}, 32'd1);
    idle(1);
    chk("R9 pulse one clock", {31'd0, reset_pulse}, 32'd0);
    chk("R1 step after reload", phase, 32'h9000_1001);

    // R2/R3 PAL automatic
    pal_mode = 1; phase_offset = 32'h0;
    do_reset();
    fields(7);
    chk("R2 PAL field 7", {29'd0, field_num}, 32'd7);
    strobe();
    chk("R3 PAL wrap phase", phase, 32'h0);
    chk("R2 PAL wrap field", {29'd0, field_num}, 32'd0);

    // R4 deferred request in PAL field 5
    seq_reset_en = 0; req_reset_en = 1; phase_offset = 32'hDEAD_0000; freq_inc = 32'h0123_4567;
    do_reset();
    fields(5);
    request();
    idle(2);
    chk("R4 field kept after request", {29'd0, field_num}, 32'd5);
    strobe();
    chk("R4 field 0 after boundary", {29'd0, field_num}, 32'd0);
    chk("R4 phase reloaded", phase, 32'hDEAD_0000);
    chk("R9 pulse with request reload", {31'd0, reset_pulse}, 32'd1);

    // R5 request coincident with strobe
    idle(3);
    @(negedge clk) begin field_start = 1; ext_reset_req = 1; end
    @(negedge clk) begin field_start = 0; ext_reset_req = 0; end
    chk("R5 no reload on same strobe", {31'd0, reset_pulse}, 32'd0);
    chk("R5 field advanced", {29'd0, field_num}, 32'd1);
    idle(3);
    strobe();
    chk("R5 reload at next strobe", {31'd0, reset_pulse}, 32'd1);
    chk("R5 field 0", {29'd0, field_num}, 32'd0);

    // R6 free running with requests enabled but none raised
    do_reset();
    npulse = 0;
    fields(20);
    chk("R6 no reload over 20 fields", npulse, 32'd0);

    // R7 real-time-control mode
    seq_reset_en = 1; req_reset_en = 1; pal_mode = 0;
    do_reset();
    npulse = 0;
    fields(10);
    chk("R7 no automatic reload", npulse, 32'd0);
    request();
    strobe();
    chk("R7 request honoured", {31'd0, reset_pulse}, 32'd1);
    chk("R7 phase reloaded", phase, 32'hDEAD_0000);

    // R8 both off
    seq_reset_en = 0; req_reset_en = 0;
    do_reset();
    npulse = 0;
    for (int i = 0; i < 6; i++) begin
      request();
      strobe();
      idle(2);
    end
    chk("R8 requests ignored", npulse, 32'd0);
    chk("R8 field keeps counting", {29'd0, field_num}, 32'd2);

    // R11 pending discarded
    req_reset_en = 1;
    do_reset();
    fields(1);
    request();
    @(negedge clk) req_reset_en = 0;
    @(negedge clk) req_reset_en = 1;
    p0 = npulse;
    strobe();
    chk("R11 discarded request", {31'd0, reset_pulse}, 32'd0);
    chk("R11 field advanced", {29'd0, field_num}, 32'd2);
    chk("R11 no pulse", npulse, p0);

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule